// File: doc/BRIEF.md
# Indexed Set/Clear Interrupt Mask Controller

This block arbitrates among 64 level-sensitive interrupt request lines. It keeps one mask bit for each source and a 3-bit priority level for each source. From these it reports the single pending, unmasked source with the highest level, along with that level and a flag that shows a winner exists. The outputs follow the request lines combinationally and follow register state one clock after a write.

Software never has to read, modify and write the 64-bit mask. To mask one source, it writes the source number to a set-index byte register. To unmask one source, it writes the number to a clear-index byte register. If bit 6 of the written value is 1, the write acts on all sources at once, so the value 0xFF masks every source. Each source's level lives in its own byte register. The mask, the level registers and the raw request lines can all be read back through a small read port.

Register map: address 0x00 is the set-index register and 0x01 is the clear-index register. Addresses 0x08 to 0x0F read the mask, with byte k holding bits 8k+7 to 8k. Addresses 0x10 to 0x17 read the request lines with the same byte layout. Addresses 0x40 to 0x7F are the level registers, where address 0x40+n belongs to source n. Reads of any other address return 0.

Top module: `imask_ctrl`

## Requirements
- R1: After reset, every mask bit is 1, every level is 0, and `irq_pending`, `win_level` and `win_index` are all 0.
- R2: A write to 0x00 with data bit 6 = 0 sets mask bit data[5:0] and leaves all other mask bits unchanged.
- R3: A write to 0x01 with data bit 6 = 0 clears mask bit data[5:0] and leaves all other mask bits unchanged.
- R4: A write to 0x00 with data bit 6 = 1 (for example 0xFF) sets all 64 mask bits.
- R5: A write to 0x01 with data bit 6 = 1 clears all 64 mask bits.
- R6: A write to 0x40+n stores data[2:0] as the level of source n. A read of 0x40+n returns that level in bits 2:0, with bits 7:3 read as 0.
- R7: When some source has its request at 1, its mask bit at 0 and a nonzero level, `irq_pending` is 1. In that case `win_level` is the highest such level and `win_index` is the number of that source.
- R8: When two or more such sources share the highest level, `win_index` is the lowest of their source numbers.
- R9: A masked source never wins, and neither does a source with level 0. When no source qualifies, `irq_pending`, `win_level` and `win_index` are all 0.
- R10: A read of 0x08+k returns mask bits 8k+7..8k, and a read of 0x10+k returns request lines 8k+7..8k, for k from 0 to 7.
- R11: A write to any address outside 0x00, 0x01 and 0x40–0x7F changes neither the mask nor any level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 64 | Level interrupt request lines, one per source |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational |
| irq_pending | output | 1 | A qualifying source exists |
| win_level | output | 3 | Level of the winning source |
| win_index | output | 6 | Number of the winning source |

## Verification
The hardest case to reach is a tie at the top level, because it needs several sources that are requesting, unmasked and set to the same level all at once. The stimulus builds it on purpose: it gives sources 3 and 10 the same level and unmasks them one at a time. It then masks the higher-level source that was beating them, so only the tie decides the winner. The level-0 case is set up the same way: a requesting, unmasked source at level 0 stays visible on the pending read-back but is passed over. Randomized rounds then mix the request, level and single-index mask patterns and compare the outputs with a model in the bench.

// File: rtl/imask_ctrl.sv
module imask_ctrl #(
  parameter int NSRC = 64,
  parameter int LW   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] req,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [7:0]  rd_addr,
  output logic [7:0]  rd_data,
  output logic        irq_pending,
  output logic [2:0]  win_level,
  output logic [5:0]  win_index
);
  localparam int IW = $clog2(NSRC);

  logic [NSRC-1:0] mask;
  logic [LW-1:0]   lvl [NSRC];
  logic [LW-1:0]   best_l;
  logic [IW-1:0]   best_i;

  wire wr_set = wr_en && wr_addr == 8'h00;
  wire wr_clr = wr_en && wr_addr == 8'h01;
  wire wr_lvl = wr_en && wr_addr[7:6] == 2'b01;
  wire every  = wr_data[6];
  wire unused_bit = wr_data[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '1;
    end else if (wr_set) begin
      if (every) mask <= '1;
      else       mask[wr_data[IW-1:0]] <= 1'b1;
    end else if (wr_clr) begin
      if (every) mask <= '0;
      else       mask[wr_data[IW-1:0]] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) lvl[i] <= '0;
    end else if (wr_lvl) begin
      lvl[wr_addr[IW-1:0]] <= wr_data[LW-1:0];
    end
  end

  always_comb begin
    best_l = '0;
    best_i = '0;
    for (int i = 0; i < NSRC; i++)
      if (req[i] && !mask[i] && lvl[i] > best_l) begin
        best_l = lvl[i];
        best_i = IW'(i);
      end
  end

  assign irq_pending = best_l != '0;
  assign win_level   = best_l;
  assign win_index   = best_i;

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr[7:6] == 2'b01)
      rd_data = {{(8-LW){1'b0}}, lvl[rd_addr[IW-1:0]]};
    else if (rd_addr[7:3] == 5'b00001)
      rd_data = mask[rd_addr[2:0]*8 +: 8];
    else if (rd_addr[7:3] == 5'b00010)
      rd_data = req[rd_addr[2:0]*8 +: 8];
  end

  // R2
  set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && !every) |=> mask[$past(wr_data[IW-1:0])]);
  // R3
  clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !every) |=> !mask[$past(wr_data[IW-1:0])]);
  // R4
  set_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && every) |=> (&mask));
  // R5
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && every) |=> (mask == '0));
  // R11
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(mask));
  // R7
  winner_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (req[win_index] && !mask[win_index] && lvl[win_index] == win_level));
  // R9
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pending |-> (win_level == 3'd0 && win_index == 6'd0));
endmodule

// File: tb/imask_ctrl_test.sv
module imask_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] req = '0;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0]  rd_data;
  logic        irq_pending;
  logic [2:0]  win_level;
  logic [5:0]  win_index;

  imask_ctrl uut (.*);

  always #10 clk = ~clk;

  typedef struct {
    bit        is_rd;
    logic [7:0] addr;
    logic [9:0] exp;
    string     tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  logic [63:0] m_mask;
  logic [2:0]  m_lvl [64];

  always begin
    wait (q.size() > 0);
    @(negedge clk);
    if (q[0].is_rd) rd_addr = q[0].addr;
    #1;
    checks++;
    if (q[0].is_rd) begin
      if (rd_data !== q[0].exp[7:0]) begin
        errors++;
        $display("FAIL %s read %h: got %h expected %h", q[0].tag, q[0].addr, rd_data, q[0].exp[7:0]);
      end
    end else if ({irq_pending, win_level, win_index} !== q[0].exp) begin
      errors++;
      $display("FAIL %s outputs: got p=%0d l=%0d i=%0d expected p=%0d l=%0d i=%0d", q[0].tag,
               irq_pending, win_level, win_index, q[0].exp[9], q[0].exp[8:6], q[0].exp[5:0]);
    end
    void'(q.pop_front());
  end

  task automatic exp_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.is_rd = 1; it.addr = a; it.exp = {2'b0, e}; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  function automatic logic [9:0] model_win();
    logic [2:0] bl = 0;
    logic [5:0] bi = 0;
    for (int i = 0; i < 64; i++)
      if (req[i] && !m_mask[i] && m_lvl[i] > bl) begin bl = m_lvl[i]; bi = 6'(i); end
    return {bl != 0, bl, bi};
  endfunction

  task automatic exp_out(input string tag);
    item_t it;
    it.is_rd = 0; it.addr = 0; it.exp = model_win(); it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a == 8'h00) begin if (d[6]) m_mask = '1; else m_mask[d[5:0]] = 1; end
    else if (a == 8'h01) begin if (d[6]) m_mask = '0; else m_mask[d[5:0]] = 0; end
    else if (a[7:6] == 2'b01) m_lvl[a[5:0]] = d[2:0];
  endtask

  task automatic check_mask(input string tag);
    for (int k = 0; k < 8; k++) exp_rd(8'h08 + 8'(k), m_mask[k*8 +: 8], tag);
  endtask

  initial begin
    m_mask = '1;
    for (int i = 0; i < 64; i++) m_lvl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_mask("R1");
    exp_rd(8'h45, 8'h00, "R1");
    exp_out("R1");

    req = 64'h8000_0100_0000_0408;
    for (int k = 0; k < 8; k++) exp_rd(8'h10 + 8'(k), req[k*8 +: 8], "R10");

    wr(8'h43, 8'h05); wr(8'h4A, 8'h05); wr(8'h68, 8'h07); wr(8'h7F, 8'hFA);
    exp_rd(8'h7F, 8'h02, "R6");
    exp_rd(8'h43, 8'h05, "R6");
    exp_out("R9 all masked");

    wr(8'h01, 8'h03);
    exp_rd(8'h08, 8'hF7, "R3");
    exp_out("R7 single");
    wr(8'h01, 8'h0A);
    exp_out("R8 tie");
    if (win_index !== 6'd3) begin errors++; $display("FAIL R8 tie index got %0d expected 3", win_index); end
    checks++;

    wr(8'h01, 8'h40);
    check_mask("R5");
    exp_out("R7 highest");
    wr(8'h00, 8'h28);
    exp_rd(8'h0D, 8'h01, "R2");
    exp_rd(8'h08, 8'h00, "R2");
    exp_out("R8 tie after mask");

    req[7] = 1;
    req[3] = 0; req[10] = 0;
    exp_out("R9 level zero");
    exp_rd(8'h10, 8'h80, "R10");

    wr(8'h20, 8'h40); wr(8'h10, 8'h00); wr(8'h02, 8'h05);
    check_mask("R11");
    exp_rd(8'h7F, 8'h02, "R11");
    exp_out("R11");

    wr(8'h00, 8'hFF);
    check_mask("R4");
    exp_out("R4 R9");
    wr(8'h01, 8'h40);

    for (int r = 0; r < 30; r++) begin
      req = {$urandom, $urandom};
      for (int j = 0; j < 4; j++) wr(8'h40 + 8'($urandom_range(0, 63)), 8'($urandom));
      wr(8'(($urandom_range(0, 1))), 8'($urandom_range(0, 63)));
      exp_out("R7 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule